// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a 32-bit physical address into a chip-select for one of four DRAM rows. Each row is described by a single 8-bit limit register that holds the top byte of the row's exclusive upper address, so rows are sized in 16 MiB steps. The limits are cumulative. Row 0 begins at address zero. Every later row begins at the limit of the row before it.

Software programs the four limits through a small write-only register port. The memory pipeline then presents an address together with a valid strobe. One cycle later the block returns a one-hot chip-select, the binary row number and a hit flag. A row whose limit does not rise above the limit of its predecessor is empty, and no address ever selects it. A module of 16 MiB to 512 MiB fits in one row, which is 1 to 32 limit steps.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset all four limits are 0. Every lookup then misses: `sel_hit`=0, `sel_cs`=0, `sel_row`=0.
- R2: `sel_valid` is high in exactly the cycle after a cycle with `lookup_valid` high. While `sel_valid` is low, `sel_cs`, `sel_row` and `sel_hit` are 0.
- R3: Row n covers the addresses from (limit of row n-1) << 24, or from 0 for row 0, up to but not including (limit of row n) << 24. Address bits 23:0 do not move a boundary. An address one below a limit hits the lower row, and the address equal to the limit does not.
- R4: A row whose limit equals its predecessor's limit is never selected. Addresses past the previous limit go to the next non-empty row.
- R5: An address at or above the highest programmed limit misses: `sel_hit`=0, `sel_cs`=0, `sel_row`=0. With a limit of 0xFF, the address 0xFEFFFFFF still hits and 0xFF000000 misses.
- R6: A row whose limit is below its predecessor's limit is empty and is never selected. The decoder picks the lowest-numbered non-empty row whose limit is above the address.
- R7: On a hit, `sel_cs` has exactly bit n set and `sel_row` equals n, where n is the selected row (bit 0 = row 0).
- R8: A write with `csr_we`=1 loads `csr_wdata` into the limit register chosen by `csr_sel` (0 to 3 = row 0 to 3). A lookup presented in the cycle right after the write already uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Limit register write strobe |
| csr_sel | input | 2 | Row whose limit is written |
| csr_wdata | input | 8 | New limit, address bits 31:24 of the row's exclusive top |
| lookup_valid | input | 1 | Address strobe |
| lookup_addr | input | 32 | Physical address to decode |
| sel_valid | output | 1 | Result valid, one cycle after `lookup_valid` |
| sel_cs | output | 4 | One-hot chip-select, bit n = row n |
| sel_row | output | 2 | Selected row number |
| sel_hit | output | 1 | Address falls inside a non-empty row |

## Verification
The hardest situations to reach from the ports are the ones where priority and emptiness interact. One is a row whose limit drops below its predecessor's while a later row still has a larger limit. The other is a lookup that lands in the very cycle after a limit write. The stimulus programs deliberately non-monotonic and duplicated limit sets. It then probes each boundary at the limit itself and one byte below it. It also issues one lookup right behind a write, so the new value must already take effect, and it runs back-to-back lookups so that the pipeline timing is exercised every cycle.

// File: rtl/drd_pkg.sv
package drd_pkg;
  localparam int unsigned DRD_ROWS_DEF   = 4;
  localparam int unsigned DRD_LIM_W_DEF  = 8;
  localparam int unsigned DRD_ADDR_W_DEF = 32;
endpackage

// File: rtl/drd_limit_regs.sv
module drd_limit_regs #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned LIM_W = 8,
  localparam int unsigned SEL_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [SEL_W-1:0]           wr_sel,
  input  logic [LIM_W-1:0]           wr_data,
  output logic [ROWS-1:0][LIM_W-1:0] lim_q
);
  for (genvar r = 0; r < ROWS; r++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst) begin
        lim_q[r] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(r))) begin
        lim_q[r] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/drd_row_match.sv
module drd_row_match #(
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LOW_W = ADDR_W - LIM_W
) (
  input  logic [LIM_W-1:0]  lim_self,
  input  logic [LIM_W-1:0]  lim_prev,
  input  logic [ADDR_W-1:0] addr,
  output logic              candidate
);
  logic [ADDR_W-1:0] top_addr;
  logic              populated;
  logic              below_top;

  assign top_addr  = {lim_self, {LOW_W{1'b0}}};
  // non-monotonic or repeated limit: row holds nothing
  assign populated = lim_self > lim_prev;
  assign below_top = addr < top_addr;
  assign candidate = populated && below_top;
endmodule

// File: rtl/drd_pick.sv
module drd_pick #(
  parameter int unsigned ROWS = 4,
  localparam int unsigned IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [ROWS-1:0]  cand,
  output logic [ROWS-1:0]  onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      if (cand[r] && !any) begin
        onehot[r] = 1'b1;
        idx       = IDX_W'(r);
        any       = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
  import drd_pkg::*;
#(
  parameter int unsigned ROWS   = DRD_ROWS_DEF,
  parameter int unsigned LIM_W  = DRD_LIM_W_DEF,
  parameter int unsigned ADDR_W = DRD_ADDR_W_DEF,
  localparam int unsigned SEL_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [SEL_W-1:0]  csr_sel,
  input  logic [LIM_W-1:0]  csr_wdata,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              sel_valid,
  output logic [ROWS-1:0]   sel_cs,
  output logic [SEL_W-1:0]  sel_row,
  output logic              sel_hit
);
  logic [ROWS-1:0][LIM_W-1:0] lim_q;
  logic [ROWS-1:0]            cand;
  logic [ROWS-1:0]            pick_oh;
  logic [SEL_W-1:0]           pick_idx;
  logic                       pick_any;

  drd_limit_regs #(.ROWS(ROWS), .LIM_W(LIM_W)) lim_regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (csr_we),
    .wr_sel  (csr_sel),
    .wr_data (csr_wdata),
    .lim_q   (lim_q)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [LIM_W-1:0] lim_below;
    if (r == 0) begin : g_first
      assign lim_below = '0;
    end else begin : g_rest
      assign lim_below = lim_q[r-1];
    end
    drd_row_match #(.LIM_W(LIM_W), .ADDR_W(ADDR_W)) match_i (
      .lim_self  (lim_q[r]),
      .lim_prev  (lim_below),
      .addr      (lookup_addr),
      .candidate (cand[r])
    );
  end

  drd_pick #(.ROWS(ROWS)) pick_i (
    .cand   (cand),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_cs    <= '0;
      sel_row   <= '0;
      sel_hit   <= 1'b0;
    end else begin
      sel_valid <= lookup_valid;
      sel_cs    <= lookup_valid ? pick_oh  : '0;
      sel_row   <= lookup_valid ? pick_idx : '0;
      sel_hit   <= lookup_valid && pick_any;
    end
  end
endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk #(
  parameter int unsigned ROWS  = 4,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             lookup_valid,
  input logic             sel_valid,
  input logic [ROWS-1:0]  sel_cs,
  input logic [SEL_W-1:0] sel_row,
  input logic             sel_hit
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> sel_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> (!sel_valid && sel_cs == '0 && !sel_hit && sel_row == '0));

  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_cs));

  assert_hit_has_cs_R7: assert property (@(posedge clk) disable iff (rst)
    sel_hit == (sel_cs != '0));

  assert_row_matches_cs_R7: assert property (@(posedge clk) disable iff (rst)
    sel_hit |-> sel_cs[sel_row]);

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !sel_hit |-> (sel_row == '0 && sel_cs == '0));
endmodule

bind dram_row_decoder dram_row_decoder_chk #(.ROWS(ROWS), .SEL_W(SEL_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .lookup_valid (lookup_valid),
  .sel_valid    (sel_valid),
  .sel_cs       (sel_cs),
  .sel_row      (sel_row),
  .sel_hit      (sel_hit)
);

// File: tb/dram_row_decoder_tb_top.sv
module dram_row_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [7:0]  csr_wdata = '0;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_addr = '0;
  logic        sel_valid;
  logic [3:0]  sel_cs;
  logic [1:0]  sel_row;
  logic        sel_hit;

  typedef struct {
    logic [3:0] cs;
    logic [1:0] row;
    logic       hit;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] shadow [4];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_row_decoder dut_i (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .lookup_valid(lookup_valid),
    .lookup_addr(lookup_addr), .sel_valid(sel_valid), .sel_cs(sel_cs),
    .sel_row(sel_row), .sel_hit(sel_hit)
  );

  // Range model: row n owns [prev<<24, lim<<24) when lim > prev
  function automatic exp_t model(input logic [31:0] a, input string tag);
    exp_t e;
    e.cs = '0; e.row = '0; e.hit = 1'b0; e.tag = tag;
    for (int n = 0; n < 4; n++) begin
      logic [32:0] lo, hi;
      lo = (n == 0) ? 33'd0 : {1'b0, shadow[n-1], 24'd0};
      hi = {1'b0, shadow[n], 24'd0};
      if (!e.hit && hi > lo && {1'b0, a} >= lo && {1'b0, a} < hi) begin
        e.hit = 1'b1; e.row = 2'(n); e.cs = 4'(1 << n);
      end
    end
    return e;
  endfunction

  task automatic wr(input int idx, input logic [7:0] v);
    csr_we = 1'b1; csr_sel = 2'(idx); csr_wdata = v;
    shadow[idx] = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic program4(input logic [7:0] a, b, c, d);
    wr(0, a); wr(1, b); wr(2, c); wr(3, d);
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    csr_we = 1'b0;
    lookup_valid = 1'b1; lookup_addr = a;
    exp_q.push_back(model(a, tag));
    @(negedge clk);
    lookup_valid = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    compared++;
    if (sel_valid !== 1'b0 || sel_cs !== 4'd0 || sel_hit !== 1'b0 || sel_row !== 2'd0) begin
      mismatched++;
      $display("FAIL %s idle: valid=%b cs=%b row=%0d hit=%b expected all 0",
               tag, sel_valid, sel_cs, sel_row, sel_hit);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && sel_valid === 1'b1) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R2 unexpected result: cs=%b row=%0d hit=%b expected none",
                 sel_cs, sel_row, sel_hit);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (sel_cs !== e.cs || sel_row !== e.row || sel_hit !== e.hit) begin
          mismatched++;
          $display("FAIL %s: cs=%b row=%0d hit=%b expected cs=%b row=%0d hit=%b",
                   e.tag, sel_cs, sel_row, sel_hit, e.cs, e.row, e.hit);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_idle("R1 reset");
    // R1: all rows empty after reset
    look(32'h0000_0000, "R1 addr zero");
    look(32'hFFFF_FFFF, "R1 addr max");
    check_idle("R2 after lookups");

    // R4: row 1 empty (same limit as row 0)
    program4(8'h08, 8'h08, 8'h18, 8'h20);
    look(32'h0000_0000, "R3 row0 base");
    look(32'h07FF_FFFF, "R3 row0 top byte");
    look(32'h0800_0000, "R4 skip empty row1");
    look(32'h17FF_FFFF, "R3 row2 top");
    look(32'h1800_0000, "R3 row3 base");
    look(32'h1FFF_FFFF, "R7 row3 top");
    look(32'h2000_0000, "R5 at last limit");
    look(32'hFFFF_FFFF, "R5 far above");
    check_idle("R2 gap");

    // R8: lookup in cycle right after write
    wr(3, 8'h40);
    look(32'h3000_0000, "R8 write then lookup");
    check_idle("R2 gap2");

    // R6: non-monotonic row 1
    program4(8'h10, 8'h08, 8'h20, 8'h30);
    look(32'h0C00_0000, "R6 low in row0");
    look(32'h0800_0000, "R6 not row1");
    look(32'h1200_0000, "R6 row2");
    look(32'h2FFF_FFFF, "R6 row3");
    look(32'h3000_0000, "R5 above");

    // R5: full range
    program4(8'h40, 8'h80, 8'hC0, 8'hFF);
    look(32'h4000_0000, "R7 row1 base");
    look(32'hBFFF_FFFF, "R7 row2 top");
    look(32'hFEFF_FFFF, "R5 below 0xFF limit");
    look(32'hFF00_0000, "R5 at 0xFF limit");
    check_idle("R2 tail");
    repeat (3) @(negedge clk);

    compared++;
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R2 results missing: %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule